// File: doc/BRIEF.md
# Multi-Stream Slot Rate Governor

This block paces one video stream inside the repeating transfer packets of a multi-stream transmit link. At each packet boundary a one-cycle start strobe arrives. The block then decides whether the coming packet carries the stream's full allocated number of time slots, or a smaller count where the gap is filled with payload fill symbols. It also reports which of the two it chose. The decision follows a 1/64-resolution fractional average value that software programs. That value is the fractional part of the target average slots per packet, times 64, rounded up.

Stream symbols are laid onto the link in groups of four symbols spread across the active lanes. Because of this, one fill insertion costs one slot on four lanes, two slots on two lanes and four slots on one lane. With narrow links, a fill rate tuned for four lanes therefore removes too much payload, and the stream gradually overruns the link. When the compensation input is set, the block rescales the fill rate by the lane count itself. The delivered average then matches the target on any lane count.

The schedule uses a phase accumulator. Each strobe adds a step that is derived from the fraction, and a carry out of the accumulator marks a packet that gets fill. A zero fraction turns fill off completely.

Top module: `mst_rate_governor`

## Requirements
- R1: All inputs are sampled only on a cycle where `mtp_stb` is high. `mtp_slots` and `vcpf_req` update on the clock edge that samples the strobe and are valid from the following cycle. They hold their value until the next strobe.
- R2: Synchronous active-high reset clears the accumulator to 0 and drives `mtp_slots` to 0 and `vcpf_req` to 0.
- R3: When `avg_frac` is 0, no fill is requested and `mtp_slots` equals `alloc_slots`, whatever the values of `comp_en` and `lane_cnt`.
- R4: With `comp_en` low and `avg_frac` = f > 0, each strobe adds step = 64 − f to a 6-bit accumulator. The strobe gets fill (`vcpf_req` = 1) exactly when the sum reaches 64 or more. The accumulator keeps the sum modulo 64. For example, f = 32 starting from reset gives no-fill, fill, no-fill, fill.
- R5: With `comp_en` high, step = floor((64 − f) × lanes / 4). For f = 32 starting from reset, fill falls on every 2nd, 4th and 8th strobe for 4, 2 and 1 lanes.
- R6: A filled packet carries `alloc_slots` minus 1, 2 or 4 slots for 4, 2 or 1 lanes, clamped at 0.
- R7: Any `lane_cnt` code other than 1 or 2 acts as 4 lanes, both for the reduction and for the compensated step.
- R8: Input changes on cycles without a strobe have no effect on the outputs.
- R9: With compensation, f = 32 and 9 allocated slots delivers 34 slots over 4 packets on two lanes and 68 slots over 8 packets on one lane. Without compensation the same setting delivers 32 and 56.
- R10: A strobe with `avg_frac` = 0 leaves the accumulator unchanged, so the fill phase resumes from where it stood.
- R11: With compensation on one lane, f ≥ 61 gives a step of 0, and no fill is ever requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mtp_stb | input | 1 | One-cycle packet start strobe |
| alloc_slots | input | SLOT_W | Allocated stream time slots per packet |
| avg_frac | input | FRAC_W | Fractional average, scaled by 64 |
| lane_cnt | input | 3 | Active lane count (1, 2, 4; others act as 4) |
| comp_en | input | 1 | Enable lane-count compensation of the fraction |
| mtp_slots | output | SLOT_W | Stream slots granted to the current packet |
| vcpf_req | output | 1 | Payload fill requested for the current packet |

## Verification
The hardest state to reach from the ports is the accumulator's phase. It is never visible directly and shows only as the timing of later fill decisions. Each phase claim therefore needs a known starting point followed by a run of strobes. The stimulus resets the block before each directed sequence. It places zero-fraction strobes between strobes with a non-zero fraction to show that the phase is preserved, and it lets a long random run switch fractions, lane codes and compensation while a bench model tracks the phase independently. Changing the inputs between strobes and re-reading the outputs exercises the sampling rule.

// File: rtl/mst_rg_pkg.sv
package mst_rg_pkg;

    localparam int LANE_W = 3;

    typedef enum logic [1:0] {
        LM_ONE  = 2'd0,
        LM_TWO  = 2'd1,
        LM_FOUR = 2'd2
    } lane_mode_e;

    typedef struct packed {
        logic       insert;
        lane_mode_e mode;
    } mtp_decision_t;

    // lane codes outside {1,2} fall back to the widest link
    function automatic lane_mode_e lane_mode(input logic [LANE_W-1:0] code);
        case (code)
            3'd1:    return LM_ONE;
            3'd2:    return LM_TWO;
            default: return LM_FOUR;
        endcase
    endfunction

    // log2 of (4 / lanes): scales the step and the slot reduction
    function automatic logic [1:0] lane_shift(input lane_mode_e m);
        case (m)
            LM_ONE:  return 2'd2;
            LM_TWO:  return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/rg_tavg_comp.sv
module rg_tavg_comp
    import mst_rg_pkg::*;
#(
    parameter int FRAC_W = 6
) (
    input  logic [FRAC_W-1:0] frac,
    input  lane_mode_e        mode,
    input  logic              comp_en,
    output logic [FRAC_W:0]   step,
    output logic              active
);
    localparam logic [FRAC_W:0] SCALE = (FRAC_W+1)'(1) << FRAC_W;

    logic [FRAC_W:0] deficit;

    always_comb begin
        deficit = SCALE - {1'b0, frac};
        active  = (frac != '0);
        if (comp_en) begin
            step = deficit >> lane_shift(mode);
        end else begin
            step = deficit;
        end
    end
endmodule

// File: rtl/rg_phase_acc.sv
module rg_phase_acc #(
    parameter int FRAC_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stb,
    input  logic            active,
    input  logic [FRAC_W:0] step,
    output logic            carry
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    always_comb begin
        sum   = {1'b0, acc_q} + step;
        carry = active & sum[FRAC_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (stb && active) begin
            acc_q <= sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/rg_slot_sel.sv
module rg_slot_sel
    import mst_rg_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  mtp_decision_t     dec,
    input  logic [SLOT_W-1:0] alloc,
    output logic [SLOT_W-1:0] slots_q,
    output logic              fill_q
);
    logic [SLOT_W-1:0] cut;
    logic [SLOT_W-1:0] granted;

    always_comb begin
        cut = SLOT_W'(1) << lane_shift(dec.mode);
        if (!dec.insert) begin
            granted = alloc;
        end else if (alloc > cut) begin
            granted = alloc - cut;
        end else begin
            granted = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
            fill_q  <= 1'b0;
        end else if (stb) begin
            slots_q <= granted;
            fill_q  <= dec.insert;
        end
    end
endmodule

// File: rtl/mst_rate_governor.sv
module mst_rate_governor
    import mst_rg_pkg::*;
#(
    parameter int SLOT_W = 6,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mtp_stb,
    input  logic [SLOT_W-1:0] alloc_slots,
    input  logic [FRAC_W-1:0] avg_frac,
    input  logic [2:0]        lane_cnt,
    input  logic              comp_en,
    output logic [SLOT_W-1:0] mtp_slots,
    output logic              vcpf_req
);
    lane_mode_e      mode;
    logic [FRAC_W:0] step;
    logic            active;
    logic            carry;
    mtp_decision_t   dec;

    assign mode = lane_mode(lane_cnt);

    rg_tavg_comp #(.FRAC_W(FRAC_W)) u_comp (
        .frac    (avg_frac),
        .mode    (mode),
        .comp_en (comp_en),
        .step    (step),
        .active  (active)
    );

    rg_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .stb    (mtp_stb),
        .active (active),
        .step   (step),
        .carry  (carry)
    );

    always_comb begin
        dec.insert = carry;
        dec.mode   = mode;
    end

    rg_slot_sel #(.SLOT_W(SLOT_W)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .stb     (mtp_stb),
        .dec     (dec),
        .alloc   (alloc_slots),
        .slots_q (mtp_slots),
        .fill_q  (vcpf_req)
    );
endmodule

// File: rtl/mst_rate_governor_chk.sv
module mst_rate_governor_chk #(
    parameter int SLOT_W = 6,
    parameter int FRAC_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              mtp_stb,
    input logic [SLOT_W-1:0] alloc_slots,
    input logic [FRAC_W-1:0] avg_frac,
    input logic [2:0]        lane_cnt,
    input logic [SLOT_W-1:0] mtp_slots,
    input logic              vcpf_req
);
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !mtp_stb |=> ($stable(mtp_slots) && $stable(vcpf_req))); // R8

    AST_ZERO_FRAC_FULL: assert property (@(posedge clk) disable iff (rst)
        (mtp_stb && avg_frac == '0) |=> (!vcpf_req && mtp_slots == $past(alloc_slots))); // R3

    AST_NEVER_GROWS: assert property (@(posedge clk) disable iff (rst)
        mtp_stb |=> (mtp_slots <= $past(alloc_slots))); // R6

    AST_WIDE_CUT_ONE: assert property (@(posedge clk) disable iff (rst)
        (mtp_stb && lane_cnt != 3'd1 && lane_cnt != 3'd2 && alloc_slots != '0)
        |=> (!vcpf_req || mtp_slots == $past(alloc_slots) - SLOT_W'(1))); // R7

    AST_NO_FILL_NO_CUT: assert property (@(posedge clk) disable iff (rst)
        mtp_stb |=> (vcpf_req || mtp_slots == $past(alloc_slots))); // R1
endmodule

bind mst_rate_governor mst_rate_governor_chk #(.SLOT_W(SLOT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mtp_stb     (mtp_stb),
    .alloc_slots (alloc_slots),
    .avg_frac    (avg_frac),
    .lane_cnt    (lane_cnt),
    .mtp_slots   (mtp_slots),
    .vcpf_req    (vcpf_req)
);

// File: tb/mst_rate_governor_bench.sv
`timescale 1ns/1ps
module mst_rate_governor_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mtp_stb = 1'b0;
    logic [5:0] alloc_slots = '0;
    logic [5:0] avg_frac = '0;
    logic [2:0] lane_cnt = 3'd4;
    logic       comp_en = 1'b0;
    logic [5:0] mtp_slots;
    logic       vcpf_req;

    int total = 0;
    int bad = 0;
    int m_acc = 0;
    int last_slots = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mst_rate_governor u_mst_rate_governor (
        .clk(clk), .rst(rst), .mtp_stb(mtp_stb), .alloc_slots(alloc_slots),
        .avg_frac(avg_frac), .lane_cnt(lane_cnt), .comp_en(comp_en),
        .mtp_slots(mtp_slots), .vcpf_req(vcpf_req)
    );

    function automatic int shift_of(int l);
        return (l == 1) ? 2 : (l == 2) ? 1 : 0;
    endfunction

    function automatic int step_of(int f, int l, bit c);
        return c ? ((64 - f) >> shift_of(l)) : (64 - f);
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model(int a, int f, int l, bit c, output bit ins, output int s);
        int sum;
        ins = 1'b0;
        if (f != 0) begin
            sum   = m_acc + step_of(f, l, c);
            ins   = (sum >= 64);
            m_acc = sum % 64;
        end
        s = a;
        if (ins) s = (a > (1 << shift_of(l))) ? a - (1 << shift_of(l)) : 0;
    endtask

    task automatic do_mtp(int a, int f, int l, bit c, string tag);
        bit ins;
        int s;
        @(negedge clk);
        alloc_slots = 6'(a); avg_frac = 6'(f); lane_cnt = 3'(l); comp_en = c;
        mtp_stb = 1'b1;
        model(a, f, l, c, ins, s);
        @(negedge clk);
        mtp_stb = 1'b0;
        check(tag, int'(vcpf_req), int'(ins), "vcpf_req");
        check(tag, int'(mtp_slots), s, "mtp_slots");
        last_slots = int'(mtp_slots);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; mtp_stb = 1'b0;
        repeat (2) @(negedge clk);
        check("R2", int'(mtp_slots), 0, "mtp_slots in reset");
        check("R2", int'(vcpf_req), 0, "vcpf_req in reset");
        rst = 1'b0;
        m_acc = 0;
    endtask

    task automatic run_sum(int n, int l, bit c, int exp, string tag);
        int acc;
        acc = 0;
        do_reset();
        for (int i = 0; i < n; i++) begin
            do_mtp(9, 32, l, c, tag);
            acc += last_slots;
        end
        check(tag, acc, exp, "slot total");
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        do_reset();

        // R4: uncompensated half rate on four lanes
        for (int i = 0; i < 4; i++) do_mtp(9, 32, 4, 1'b0, "R4");

        // R5: compensated f=32 on one lane -> fill on 8th only
        do_reset();
        for (int i = 0; i < 8; i++) do_mtp(9, 32, 1, 1'b1, "R5");

        // R9: long-run totals with and without correction
        run_sum(4, 2, 1'b1, 34, "R9");
        run_sum(8, 1, 1'b1, 68, "R9");
        run_sum(4, 2, 1'b0, 32, "R9");
        run_sum(8, 1, 1'b0, 56, "R9");

        // R3: zero fraction, any mode
        do_reset();
        do_mtp(17, 0, 1, 1'b1, "R3");
        do_mtp(17, 0, 2, 1'b0, "R3");
        do_mtp(0, 0, 4, 1'b1, "R3");

        // R10: phase kept across zero-fraction strobes
        do_reset();
        do_mtp(9, 32, 4, 1'b0, "R10");
        do_mtp(9, 0, 4, 1'b0, "R10");
        do_mtp(9, 0, 4, 1'b0, "R10");
        do_mtp(9, 32, 4, 1'b0, "R10");

        // R7: odd lane code acts as four lanes
        do_reset();
        for (int i = 0; i < 4; i++) do_mtp(9, 32, 3, 1'b1, "R7");
        do_mtp(9, 32, 0, 1'b1, "R7");
        do_mtp(9, 32, 7, 1'b1, "R7");

        // R6: clamp at zero
        do_reset();
        for (int i = 0; i < 8; i++) do_mtp(2, 32, 1, 1'b1, "R6");
        do_reset();
        do_mtp(1, 1, 2, 1'b0, "R6");

        // R11: step of zero never fills
        do_reset();
        for (int i = 0; i < 6; i++) do_mtp(9, 61 + (i % 3), 1, 1'b1, "R11");

        // R1/R8: random mix; perturb inputs between strobes
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            int f;
            int hold_s;
            int hold_v;
            f = (($urandom % 8) == 0) ? 0 : int'($urandom % 64);
            do_mtp(int'($urandom % 64), f, int'($urandom % 8), 1'($urandom), "R1");
            hold_s = int'(mtp_slots);
            hold_v = int'(vcpf_req);
            alloc_slots = 6'($urandom); avg_frac = 6'($urandom);
            lane_cnt = 3'($urandom); comp_en = 1'($urandom);
            repeat (1 + ($urandom % 3)) @(negedge clk);
            check("R8", int'(mtp_slots), hold_s, "held slots");
            check("R8", int'(vcpf_req), hold_v, "held vcpf");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule